// File: doc/BRIEF.md
# Bus Quiet-Period Monitor

This block sits in a target-mode I3C device and watches the two bus lines after a STOP condition. Once a STOP is seen, it counts core clock cycles for as long as both SCL and SDA stay high. It reports three milestones on that quiet stretch, each with its own programmable cycle threshold. The first milestone is that the bus is free. The second is that the bus is available, which permits the device to start an in-band interrupt request. The third is that the bus is idle, which permits a Hot-Join request.

The line inputs are asynchronous to the core clock. They pass through a two-stage synchronizer before any condition is decoded. All three milestones share one saturating counter. A low level on either line ends the quiet stretch, and it stays ended until the next STOP. The two milestones that gate target-initiated requests are forced low whenever the target-mode enable is low. The block only reports these conditions. Producing the request traffic on the bus is left to other logic.

Top module: `bus_quiet_monitor`

## Requirements
- R1: While reset is asserted, and after reset until the first STOP has been decoded, all four outputs are low.
- R2: A STOP is an SDA rise seen after synchronization while SCL is high. It produces a `stop_pulse_o` that lasts exactly one cycle and is high in the third clock cycle after the input edge. An SDA rise that happens while SCL is low produces no pulse.
- R3: `bus_free_o` rises `free_thresh` cycles after the `stop_pulse_o` cycle, as long as both lines stay high. With a threshold of 0 it is high in the same cycle as the pulse.
- R4: `bus_avail_o` rises `avail_thresh` cycles after the `stop_pulse_o` cycle under the same condition, when `target_en` is high.
- R5: `bus_idle_o` rises `idle_thresh` cycles after the `stop_pulse_o` cycle under the same condition, when `target_en` is high.
- R6: When `target_en` is low, `bus_avail_o` and `bus_idle_o` are low in the same cycle, and `bus_free_o` is not affected. When `target_en` returns high, the two flags reappear at once if their thresholds have already been reached.
- R7: A low level on SCL or SDA clears all three flags in the second clock cycle after the input change.
- R8: After such a clear, the flags stay low even when both lines return high. They only start again after a new STOP.
- R9: The counter saturates at its all-ones value. A flag whose threshold is all ones therefore rises and then stays high indefinitely on a quiet bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level, asynchronous |
| sda_in | input | 1 | Raw SDA level, asynchronous |
| target_en | input | 1 | High when the device acts as a target |
| free_thresh | input | CNT_W | Cycles after STOP until bus free |
| avail_thresh | input | CNT_W | Cycles after STOP until bus available |
| idle_thresh | input | CNT_W | Cycles after STOP until bus idle |
| bus_free_o | output | 1 | Bus-free level flag |
| bus_avail_o | output | 1 | Bus-available level flag (target mode only) |
| bus_idle_o | output | 1 | Bus-idle level flag (target mode only) |
| stop_pulse_o | output | 1 | One-cycle STOP detect pulse |

## Verification
Each line change needs two flops to cross the synchronizer. The STOP pulse therefore appears in the third cycle after the SDA edge, and a flag with threshold N follows N cycles later. A line dropping low clears the flags in the second cycle after it changes. The mode gate on `target_en` acts in the same cycle. The scoreboard stores every expectation with the absolute cycle number derived from these latencies, and it also stores the cycle just before each edge, so that both early and late edges are caught. Line inputs are driven at falling clock edges. No `target_en` change is ever made at a falling edge where a check is due.

// File: rtl/bqm_pkg.sv
`timescale 1ns/1ps
package bqm_pkg;

  // Milestones tracked after a STOP; the index order is the flag order.
  localparam int unsigned NUM_GATES = 3;
  localparam int unsigned IDX_FREE  = 0;
  localparam int unsigned IDX_AVAIL = 1;
  localparam int unsigned IDX_IDLE  = 2;

  // Milestones that are only meaningful while acting as a target.
  localparam logic [NUM_GATES-1:0] TARGET_ONLY = 3'b110;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

endpackage

// File: rtl/bqm_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer, one chain per bit, reset to the idle-high level.
module bqm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '1;
      else        shreg <= {shreg[STAGES-2:0], d[b]};
    end

    assign q[b] = shreg[STAGES-1];
  end

endmodule

// File: rtl/bqm_cond_detect.sv
`timescale 1ns/1ps
// Decodes the STOP condition and the both-lines-high level from synced lines.
module bqm_cond_detect
  import bqm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_lines_t lines_s,
  output logic       stop_evt,
  output logic       lines_high
);

  bus_lines_t lines_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_d <= '{scl: 1'b1, sda: 1'b1};
    else        lines_d <= lines_s;
  end

  function automatic logic is_stop(input bus_lines_t now, input bus_lines_t prev);
    return now.scl && prev.scl && now.sda && !prev.sda;
  endfunction

  assign stop_evt   = is_stop(lines_s, lines_d);
  assign lines_high = lines_s.scl && lines_s.sda;

endmodule

// File: rtl/bqm_quiet_timer.sv
`timescale 1ns/1ps
// Shared saturating counter of quiet cycles since the last STOP.
module bqm_quiet_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_evt,
  input  logic             lines_high,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             stop_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      count      <= '0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= stop_evt;
      if (stop_evt) begin
        armed <= 1'b1;
        count <= '0;
      end else if (!lines_high) begin
        armed <= 1'b0;
        count <= '0;
      end else if (armed) begin
        count <= sat_inc(count);
      end
    end
  end

endmodule

// File: rtl/bqm_gate_flags.sv
`timescale 1ns/1ps
// Compares the shared count against each threshold and applies mode gating.
module bqm_gate_flags
  import bqm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                            armed,
  input  logic                            lines_high,
  input  logic                            target_en,
  input  logic [CNT_W-1:0]                count,
  input  logic [NUM_GATES-1:0][CNT_W-1:0] thresh,
  output logic [NUM_GATES-1:0]            flags
);

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic mode_ok;
    if (TARGET_ONLY[g]) begin : g_tgt
      assign mode_ok = target_en;
    end else begin : g_any
      assign mode_ok = 1'b1;
    end
    assign flags[g] = armed && lines_high && mode_ok && reached(count, thresh[g]);
  end

endmodule

// File: rtl/bus_quiet_monitor.sv
`timescale 1ns/1ps
module bus_quiet_monitor
  import bqm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             target_en,
  input  logic [CNT_W-1:0] free_thresh,
  input  logic [CNT_W-1:0] avail_thresh,
  input  logic [CNT_W-1:0] idle_thresh,
  output logic             bus_free_o,
  output logic             bus_avail_o,
  output logic             bus_idle_o,
  output logic             stop_pulse_o
);

  bus_lines_t                      lines_raw;
  bus_lines_t                      lines_s;
  logic                            stop_evt;
  logic                            lines_high;
  logic                            armed;
  logic [CNT_W-1:0]                count;
  logic [NUM_GATES-1:0][CNT_W-1:0] thresh;
  logic [NUM_GATES-1:0]            flags;

  assign lines_raw = '{scl: scl_in, sda: sda_in};

  bqm_sync #(.STAGES(SYNC_STAGES), .WIDTH($bits(bus_lines_t))) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (lines_raw),
    .q (lines_s)
  );

  bqm_cond_detect u_cond (
    .clk (clk),
    .rst_n (rst_n),
    .lines_s (lines_s),
    .stop_evt (stop_evt),
    .lines_high (lines_high)
  );

  bqm_quiet_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .stop_evt (stop_evt),
    .lines_high (lines_high),
    .armed (armed),
    .count (count),
    .stop_pulse (stop_pulse_o)
  );

  assign thresh[IDX_FREE]  = free_thresh;
  assign thresh[IDX_AVAIL] = avail_thresh;
  assign thresh[IDX_IDLE]  = idle_thresh;

  bqm_gate_flags #(.CNT_W(CNT_W)) u_flags (
    .armed (armed),
    .lines_high (lines_high),
    .target_en (target_en),
    .count (count),
    .thresh (thresh),
    .flags (flags)
  );

  assign bus_free_o  = flags[IDX_FREE];
  assign bus_avail_o = flags[IDX_AVAIL];
  assign bus_idle_o  = flags[IDX_IDLE];

endmodule

// File: rtl/bqm_checker.sv
`timescale 1ns/1ps
module bqm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             target_en,
  input logic [CNT_W-1:0] avail_thresh,
  input logic [CNT_W-1:0] idle_thresh,
  input logic             bus_free_o,
  input logic             bus_avail_o,
  input logic             bus_idle_o,
  input logic             stop_pulse_o,
  input logic             lines_high,
  input logic             armed,
  input logic [CNT_W-1:0] count
);

  // R2: the STOP pulse never lasts longer than one cycle
  assert_stop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse_o |=> !stop_pulse_o);

  // R2: a STOP pulse coincides with a freshly armed, zeroed counter
  assert_stop_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse_o |-> (armed && count == '0));

  // R6: controller mode keeps the target-only flags low
  assert_ctrl_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !target_en |-> (!bus_avail_o && !bus_idle_o));

  // R7: any low line clears every flag
  assert_low_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_high |-> !(bus_free_o || bus_avail_o || bus_idle_o));

  // R8: counting restarts only through a STOP
  assert_rearm_by_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> stop_pulse_o);

  // R9: while armed the count never moves backwards (no wrap)
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> (count >= $past(count)));

  // R5: with ordered thresholds, idle implies available
  assert_idle_implies_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle_o && (avail_thresh <= idle_thresh)) |-> bus_avail_o);

endmodule

bind bus_quiet_monitor bqm_checker #(.CNT_W(CNT_W)) u_bqm_checker (
  .clk (clk),
  .rst_n (rst_n),
  .target_en (target_en),
  .avail_thresh (avail_thresh),
  .idle_thresh (idle_thresh),
  .bus_free_o (bus_free_o),
  .bus_avail_o (bus_avail_o),
  .bus_idle_o (bus_idle_o),
  .stop_pulse_o (stop_pulse_o),
  .lines_high (lines_high),
  .armed (armed),
  .count (count)
);

// File: tb/test_bus_quiet_monitor.sv
`timescale 1ns/1ps
module test_bus_quiet_monitor;

  localparam int unsigned BW = 8;
  localparam int SIG_FREE = 0, SIG_AVAIL = 1, SIG_IDLE = 2, SIG_STOP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, tgt = 1'b1;
  logic [BW-1:0] thr_free = 8'd5, thr_avail = 8'd9, thr_idle = 8'd14;
  logic free_o, avail_o, idle_o, stop_o;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cyc;
    int    sig;
    bit    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_quiet_monitor #(.CNT_W(BW)) i_bus_quiet_monitor (
    .clk (clk), .rst_n (rst_n), .scl_in (scl), .sda_in (sda), .target_en (tgt),
    .free_thresh (thr_free), .avail_thresh (thr_avail), .idle_thresh (thr_idle),
    .bus_free_o (free_o), .bus_avail_o (avail_o), .bus_idle_o (idle_o),
    .stop_pulse_o (stop_o)
  );

  function automatic bit pick(input int sig);
    case (sig)
      SIG_FREE:  return free_o;
      SIG_AVAIL: return avail_o;
      SIG_IDLE:  return idle_o;
      default:   return stop_o;
    endcase
  endfunction

  task automatic push(input int c, input int sig, input bit v, input string tag);
    item_t it;
    it.cyc = c; it.sig = sig; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_all(input int c, input bit v, input string tag);
    push(c, SIG_FREE, v, tag);
    push(c, SIG_AVAIL, v, tag);
    push(c, SIG_IDLE, v, tag);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // START-like low on SDA, then the rising edge; p is the cycle of the rise
  task automatic issue_stop(output int p);
    sda = 1'b0;
    repeat (4) @(negedge clk);
    sda = 1'b1;
    p = cyc;
  endtask

  // Monitor: compares every queued item due at this cycle
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].cyc == cyc) begin
        bit act;
        act = pick(sb_q[i].sig);
        n_checks++;
        if (act !== sb_q[i].exp) begin
          n_fail++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%0b expected=%0b",
                   sb_q[i].tag, sb_q[i].sig, cyc, act, sb_q[i].exp);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int p, q, r, s, t, w;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    n_checks++;
    if ({free_o, avail_o, idle_o, stop_o} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b expected=0000", {free_o, avail_o, idle_o, stop_o});
    end
    rst_n = 1'b1;
    p = cyc;
    push_all(p + 10, 1'b0, "R1");
    push(p + 10, SIG_STOP, 1'b0, "R1");
    wait_to(p + 12);

    // R2..R5: STOP then quiet bus, thresholds 5/9/14
    issue_stop(p);
    push(p + 2, SIG_STOP, 1'b0, "R2");
    push(p + 3, SIG_STOP, 1'b1, "R2");
    push(p + 4, SIG_STOP, 1'b0, "R2");
    push(p + 7, SIG_FREE, 1'b0, "R3");
    push(p + 8, SIG_FREE, 1'b1, "R3");
    push(p + 11, SIG_AVAIL, 1'b0, "R4");
    push(p + 12, SIG_AVAIL, 1'b1, "R4");
    push(p + 16, SIG_IDLE, 1'b0, "R5");
    push(p + 17, SIG_IDLE, 1'b1, "R5");
    wait_to(p + 20);

    // R6: mode gate acts in the same cycle, free unaffected
    q = cyc;
    tgt = 1'b0;
    push(q + 1, SIG_AVAIL, 1'b0, "R6");
    push(q + 1, SIG_IDLE, 1'b0, "R6");
    push(q + 1, SIG_FREE, 1'b1, "R6");
    wait_to(q + 2);
    tgt = 1'b1;
    push(q + 3, SIG_AVAIL, 1'b1, "R6");
    push(q + 3, SIG_IDLE, 1'b1, "R6");
    wait_to(q + 5);

    // R7: SCL low clears all flags two cycles later
    r = cyc;
    scl = 1'b0;
    push_all(r + 1, 1'b1, "R7");
    push_all(r + 2, 1'b0, "R7");
    wait_to(r + 4);
    // R8: lines high again without a STOP keeps flags low
    scl = 1'b1;
    push(r + 7, SIG_STOP, 1'b0, "R8");
    push(r + 40, SIG_FREE, 1'b0, "R8");
    push(r + 40, SIG_IDLE, 1'b0, "R8");
    wait_to(r + 42);

    // R2: SDA rising while SCL low is no STOP
    scl = 1'b0;
    repeat (2) @(negedge clk);
    sda = 1'b0;
    repeat (2) @(negedge clk);
    sda = 1'b1;
    s = cyc;
    push(s + 3, SIG_STOP, 1'b0, "R2");
    repeat (2) @(negedge clk);
    scl = 1'b1;
    t = cyc;
    push(t + 3, SIG_STOP, 1'b0, "R2");
    push(t + 20, SIG_FREE, 1'b0, "R2");
    wait_to(t + 22);

    // R6: controller mode, free still works, target-only flags stay low
    tgt = 1'b0;
    repeat (2) @(negedge clk);
    issue_stop(p);
    push(p + 8, SIG_FREE, 1'b1, "R6");
    push(p + 20, SIG_AVAIL, 1'b0, "R6");
    push(p + 20, SIG_IDLE, 1'b0, "R6");
    wait_to(p + 22);
    tgt = 1'b1;
    w = cyc;
    push(w + 1, SIG_AVAIL, 1'b1, "R6");
    push(w + 1, SIG_IDLE, 1'b1, "R6");
    wait_to(w + 3);

    // R3: zero threshold gives the flag in the pulse cycle
    thr_free = 8'd0;
    issue_stop(p);
    push(p + 2, SIG_FREE, 1'b0, "R3");
    push(p + 3, SIG_FREE, 1'b1, "R3");
    push(p + 3, SIG_STOP, 1'b1, "R3");
    wait_to(p + 6);

    // R9: all-ones threshold reached and held by saturation
    thr_avail = 8'd200;
    thr_idle  = 8'd255;
    issue_stop(p);
    push(p + 257, SIG_IDLE, 1'b0, "R9");
    push(p + 258, SIG_IDLE, 1'b1, "R9");
    push(p + 700, SIG_IDLE, 1'b1, "R9");
    push(p + 700, SIG_AVAIL, 1'b1, "R9");
    push(p + 700, SIG_FREE, 1'b1, "R9");
    wait_to(p + 702);

    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule